// File: doc/BRIEF.md
# Multi-Granularity Reuse Distance Histogram

This block watches a stream of word addresses and builds, in a single pass, a reuse-distance histogram for four block granularities at once: blocks of 1, 2, 4 and 8 words. For each granularity the block address is the word address with its low bits removed. The reuse distance of a reference is the number of different blocks touched since the previous reference to the same block; an immediate repeat has distance 0. Each reference adds one to exactly one histogram cell per granularity.

Every granularity keeps its own 16-entry most-recently-used list and a map of blocks seen since the last clear. A reference found in the list is binned by its list position. One missing from the list but seen before goes to a far-reuse bin, and one never seen goes to a cold bin. Once the trace is over, a host reads the cells through a small read port. For a fully associative cache of n lines (n up to 16) with the matching line size, the misses are the cold count, plus the far-reuse count, plus every distance cell at n or above.

Top module: `locality_table_builder`

## Requirements
- R1: On each cycle with `ref_valid` high and `clr` low, the reference is taken at all four granularities in parallel; for selector value k (0 to 3) the block address is `ref_addr >> k`.
- R2: A reference whose block was last referenced with d distinct other blocks in between, for d from 0 to 15, increments bin d of that granularity.
- R3: A reference to a block that was seen before, but with 16 or more distinct blocks since its last reference, increments bin 16.
- R4: The first reference to a block since reset or the last clear increments bin 17.
- R5: Driving `rd_sel_b` and `rd_bin` before a rising edge makes `rd_data` show that cell after that edge. Bin codes 18 to 31 read as zero.
- R6: A cell saturates at 2^CNT_W-1 and never wraps.
- R7: A cycle with `clr` high zeroes every cell and forgets all reference history. A reference presented in the same cycle is dropped.
- R8: After reset every cell reads zero and no block counts as seen.
- R9: Each accepted reference adds exactly one count per granularity, so the bins of any granularity sum to the number of references since the last clear, as long as no cell has saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Zero all cells and history |
| ref_valid | input | 1 | Reference present this cycle |
| ref_addr | input | ADDR_W (8) | Word address of the reference |
| rd_sel_b | input | 2 | Granularity selector k (block = 2^k words) |
| rd_bin | input | 5 | Cell selector: 0-15 distance, 16 far reuse, 17 cold |
| rd_data | output | CNT_W (24) | Registered cell value |

## Verification
The assertions assume that `rd_sel_b` is always below four and that `clr` and `rst_n` are driven only between edges. The monotonic-read property compares `rd_data` on consecutive cycles only when the same cell was selected both times and no clear or reset took effect in that window. It therefore relies on the host holding the read selectors steady while it polls. The stimulus changes every input on the falling edge and holds the selectors for the whole of each read. Its addresses all lie within the address width, so the seen maps are indexed only within range.

// File: rtl/ltb_pkg.sv
// Package: shared types for the reuse locality table builder.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ltb_pkg;

    // Outcome of looking a block up in one granularity's history
    typedef enum logic [1:0] {
        REUSE_NEAR = 2'd0,  // found in the recency list
        REUSE_FAR  = 2'd1,  // seen before but aged out of the list
        REUSE_COLD = 2'd2   // never seen since reset or clear
    } reuse_kind_e;

    // Map a lookup outcome to a histogram cell index
    function automatic int unsigned bin_index(reuse_kind_e kind, int unsigned pos,
                                              int unsigned depth);
        case (kind)
            REUSE_NEAR: return pos;
            REUSE_FAR:  return depth;
            default:    return depth + 1;
        endcase
    endfunction

endpackage

// File: rtl/ltb_recency_stack.sv
// Module: most-recently-used list plus seen map for one block granularity.
// Position 0 holds the latest block. A push moves the pushed block to the
// top and shifts the entries that were above its old slot down by one; on
// a miss the whole list shifts and the oldest entry drops out.
// Assumes the list holds distinct blocks, which the update rule preserves.
module ltb_recency_stack #(
    parameter int BLK_W = 8,
    parameter int DEPTH = 16,
    localparam int POS_W = $clog2(DEPTH),
    localparam int MAP_N = 2 ** BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [BLK_W-1:0] blk,
    output logic [DEPTH-1:0] match_vec,
    output logic [POS_W-1:0] pos,
    output logic             seen
);

    logic [BLK_W-1:0] entry [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [MAP_N-1:0] seen_map;
    logic [DEPTH-1:0] shift_en;
    logic             found;

    // Compare the incoming block against every list entry
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            match_vec[i] = vld[i] && (entry[i] == blk);
        end
    end

    // Encode the matching slot into a position
    always_comb begin
        pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_vec[i]) pos = POS_W'(i);
        end
    end

    assign found = |match_vec;
    assign seen  = seen_map[blk];

    // Decide which slots take the value of the slot above them
    always_comb begin
        shift_en[0] = 1'b0;
        for (int i = 1; i < DEPTH; i++) begin
            shift_en[i] = !found || (POS_W'(i) <= pos);
        end
    end

    // Update the list and the seen map on each accepted reference
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld      <= '0;
            seen_map <= '0;
            for (int i = 0; i < DEPTH; i++) entry[i] <= '0;
        end else if (push) begin
            entry[0]      <= blk;
            vld[0]        <= 1'b1;
            seen_map[blk] <= 1'b1;
            for (int i = 1; i < DEPTH; i++) begin
                if (shift_en[i]) begin
                    entry[i] <= entry[i-1];
                    vld[i]   <= vld[i-1];
                end
            end
        end
    end

endmodule

// File: rtl/ltb_count_bank.sv
// Module: saturating counter cells for one granularity with a read mux.
// Assumes inc_bin is below NUM_BINS whenever inc is high.
module ltb_count_bank #(
    parameter int NUM_BINS = 18,
    parameter int BIN_W    = 5,
    parameter int CNT_W    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [BIN_W-1:0] inc_bin,
    input  logic [BIN_W-1:0] rd_bin,
    output logic [CNT_W-1:0] rd_val
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt [NUM_BINS];

    // Bump the addressed cell unless it is already at its ceiling
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NUM_BINS; i++) cnt[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_BINS; i++) begin
                if (inc && (inc_bin == BIN_W'(i)) && (cnt[i] != CNT_MAX)) begin
                    cnt[i] <= cnt[i] + 1'b1;
                end
            end
        end
    end

    // Select the cell to read; codes past the last cell give zero
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_BINS; i++) begin
            if (rd_bin == BIN_W'(i)) rd_val = cnt[i];
        end
    end

endmodule

// File: rtl/locality_table_builder.sv
// Module: top of the reuse locality table builder. One recency list and
// one counter bank per block granularity run side by side, so each
// reference is classified and counted at all granularities in one cycle.
// Assumes rd_sel_b stays below NUM_BSZ and addresses fit in ADDR_W bits.
module locality_table_builder #(
    parameter int ADDR_W      = 8,
    parameter int CNT_W       = 24,
    parameter int NUM_BSZ     = 4,
    parameter int STACK_DEPTH = 16,
    localparam int POS_W    = $clog2(STACK_DEPTH),
    localparam int NUM_BINS = STACK_DEPTH + 2,
    localparam int BIN_W    = $clog2(NUM_BINS),
    localparam int SEL_W    = $clog2(NUM_BSZ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ref_valid,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [SEL_W-1:0]  rd_sel_b,
    input  logic [BIN_W-1:0]  rd_bin,
    output logic [CNT_W-1:0]  rd_data
);
    import ltb_pkg::*;

    logic                                push;
    logic [NUM_BSZ-1:0][STACK_DEPTH-1:0] stk_match;
    logic [NUM_BSZ-1:0][POS_W-1:0]       stk_pos;
    logic [NUM_BSZ-1:0]                  stk_seen;
    reuse_kind_e                         kind    [NUM_BSZ];
    logic [BIN_W-1:0]                    inc_bin [NUM_BSZ];
    logic [CNT_W-1:0]                    bank_rd [NUM_BSZ];

    assign push = ref_valid && !clr;

    for (genvar g = 0; g < NUM_BSZ; g++) begin : g_gran
        ltb_recency_stack #(
            .BLK_W (ADDR_W - g),
            .DEPTH (STACK_DEPTH)
        ) u_stack (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .push      (push),
            .blk       (ref_addr[ADDR_W-1:g]),
            .match_vec (stk_match[g]),
            .pos       (stk_pos[g]),
            .seen      (stk_seen[g])
        );

        // Classify the reference for this granularity and pick its cell
        always_comb begin
            if (|stk_match[g])    kind[g] = REUSE_NEAR;
            else if (stk_seen[g]) kind[g] = REUSE_FAR;
            else                  kind[g] = REUSE_COLD;
            inc_bin[g] = BIN_W'(bin_index(kind[g], int'(stk_pos[g]), STACK_DEPTH));
        end

        ltb_count_bank #(
            .NUM_BINS (NUM_BINS),
            .BIN_W    (BIN_W),
            .CNT_W    (CNT_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .inc     (push),
            .inc_bin (inc_bin[g]),
            .rd_bin  (rd_bin),
            .rd_val  (bank_rd[g])
        );
    end

    // Register the selected cell for the host read port
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= bank_rd[rd_sel_b];
    end

endmodule

// File: rtl/ltb_checker.sv
// Module: properties for the reuse locality table builder, bound to the top.
// Assumes read selectors are held while a cell is polled.
module ltb_checker #(
    parameter int NUM_BSZ     = 4,
    parameter int STACK_DEPTH = 16,
    parameter int CNT_W       = 24,
    parameter int BIN_W       = 5,
    parameter int SEL_W       = 2,
    parameter int NUM_BINS    = 18
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                clr,
    input logic [SEL_W-1:0]                    rd_sel_b,
    input logic [BIN_W-1:0]                    rd_bin,
    input logic [CNT_W-1:0]                    rd_data,
    input logic [NUM_BSZ-1:0][STACK_DEPTH-1:0] stk_match
);

    // R7
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ##1 (rd_data == '0));

    // R5
    unused_bin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bin >= BIN_W'(NUM_BINS)) |=> (rd_data == '0));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(clr, 2) &&
         ($past(rd_bin) == $past(rd_bin, 2)) &&
         ($past(rd_sel_b) == $past(rd_sel_b, 2))) |-> (rd_data >= $past(rd_data)));

    for (genvar g = 0; g < NUM_BSZ; g++) begin : g_chk
        // R9
        single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(stk_match[g]));
    end

endmodule

bind locality_table_builder ltb_checker #(
    .NUM_BSZ     (NUM_BSZ),
    .STACK_DEPTH (STACK_DEPTH),
    .CNT_W       (CNT_W),
    .BIN_W       (BIN_W),
    .SEL_W       (SEL_W),
    .NUM_BINS    (NUM_BINS)
) u_ltb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .rd_sel_b  (rd_sel_b),
    .rd_bin    (rd_bin),
    .rd_data   (rd_data),
    .stk_match (stk_match)
);

// File: tb/test_locality_table_builder.sv
// Bench: feeds a short trace from a table, checks expected cells from a
// second table, then runs directed reset, boundary, clear and saturation tests.
module test_locality_table_builder;

    localparam int ADDR_W = 8;
    localparam int CNT_W  = 5;   // small so saturation is reachable

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              ref_valid = 1'b0;
    logic [ADDR_W-1:0] ref_addr = '0;
    logic [1:0]        rd_sel_b = '0;
    logic [4:0]        rd_bin = '0;
    logic [CNT_W-1:0]  rd_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    locality_table_builder #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_locality_table_builder (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ref_valid(ref_valid),
        .ref_addr(ref_addr), .rd_sel_b(rd_sel_b), .rd_bin(rd_bin), .rd_data(rd_data)
    );

    // Trace fed to the block
    localparam int TRACE_N = 9;
    localparam logic [7:0] TRACE [TRACE_N] = '{8'd0, 8'd8, 8'd16, 8'd0, 8'd1,
                                               8'd0, 8'd16, 8'd2, 8'd3};
    // Expected cells after the trace: {granularity, bin, count}
    localparam int EXP_N = 18;
    localparam logic [14:0] EXPECT [EXP_N] = '{
        {2'd0, 5'd17, 8'd6}, {2'd0, 5'd1, 8'd1}, {2'd0, 5'd2, 8'd2},
        {2'd0, 5'd0,  8'd0}, {2'd0, 5'd16, 8'd0},
        {2'd1, 5'd17, 8'd4}, {2'd1, 5'd0, 8'd3}, {2'd1, 5'd1, 8'd1}, {2'd1, 5'd2, 8'd1},
        {2'd2, 5'd17, 8'd3}, {2'd2, 5'd0, 8'd3}, {2'd2, 5'd1, 8'd2}, {2'd2, 5'd2, 8'd1},
        {2'd3, 5'd17, 8'd3}, {2'd3, 5'd0, 8'd3}, {2'd3, 5'd1, 8'd2}, {2'd3, 5'd2, 8'd1},
        {2'd3, 5'd3,  8'd0}
    };

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_ref(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_addr  = a;
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic send_clr(input logic with_ref, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        clr       = 1'b1;
        ref_valid = with_ref;
        ref_addr  = a;
        @(negedge clk);
        clr       = 1'b0;
        ref_valid = 1'b0;
    endtask

    task automatic read_cell(input logic [1:0] b, input logic [4:0] bin, output int val);
        @(negedge clk);
        rd_sel_b = b;
        rd_bin   = bin;
        @(negedge clk);
        val = int'(rd_data);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1: watchdog expired, actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v;
        int sum;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: all cells zero after reset
        read_cell(2'd0, 5'd17, v); check(v, 0, "R8 reset cold cell");
        read_cell(2'd3, 5'd0,  v); check(v, 0, "R8 reset distance cell");

        // R1 R2 R4: trace walk, then table of expected cells
        for (int i = 0; i < TRACE_N; i++) send_ref(TRACE[i]);
        for (int i = 0; i < EXP_N; i++) begin
            read_cell(EXPECT[i][14:13], EXPECT[i][12:8], v);
            check(v, int'(EXPECT[i][7:0]), "R1/R2/R4 trace cell");
        end

        // R9: bins of each granularity sum to the reference count
        for (int b = 0; b < 4; b++) begin
            sum = 0;
            for (int k = 0; k < 18; k++) begin
                read_cell(2'(b), 5'(k), v);
                sum += v;
            end
            check(sum, TRACE_N, "R9 bin sum");
        end

        // R5: unused bin codes read zero
        read_cell(2'd1, 5'd20, v); check(v, 0, "R5 bin 20");
        read_cell(2'd0, 5'd31, v); check(v, 0, "R5 bin 31");

        // R2 boundary: distance 15 still lands in bin 15
        send_clr(1'b0, '0);
        read_cell(2'd1, 5'd0, v); check(v, 0, "R7 clear zeroes cell");
        send_ref(8'd0);
        for (int a = 1; a <= 15; a++) send_ref(8'(a));
        send_ref(8'd0);
        read_cell(2'd0, 5'd15, v); check(v, 1, "R2 distance 15");
        read_cell(2'd0, 5'd16, v); check(v, 0, "R3 no far reuse at 15");

        // R3: sixteen distinct blocks in between gives far reuse
        send_clr(1'b0, '0);
        send_ref(8'd0);
        for (int a = 1; a <= 16; a++) send_ref(8'(a));
        send_ref(8'd0);
        read_cell(2'd0, 5'd16, v); check(v, 1,  "R3 far reuse");
        read_cell(2'd0, 5'd15, v); check(v, 0,  "R3 not in bin 15");
        read_cell(2'd0, 5'd17, v); check(v, 17, "R4 cold count");
        read_cell(2'd1, 5'd8,  v); check(v, 1,  "R1 coarse distance 8");

        // R7: reference in the clear cycle is dropped, history forgotten
        send_clr(1'b1, 8'd5);
        send_ref(8'd5);
        read_cell(2'd0, 5'd17, v); check(v, 1, "R7 cold after clear");
        read_cell(2'd0, 5'd0,  v); check(v, 0, "R7 dropped reference");

        // R6: saturation at 2^CNT_W-1
        send_clr(1'b0, '0);
        for (int i = 0; i < 40; i++) send_ref(8'd0);
        read_cell(2'd0, 5'd0,  v); check(v, 31, "R6 saturate fine");
        read_cell(2'd3, 5'd0,  v); check(v, 31, "R6 saturate coarse");
        read_cell(2'd0, 5'd17, v); check(v, 1,  "R6 cold untouched");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule